// File: doc/BRIEF.md
# Page-wide Hamming ECC engine

This block sits beside the data path between a host and a NAND flash device and computes a single Hamming-style code over the whole data area of a page. It does not split the page into sub-blocks. Each data word that crosses the bus is folded into two 16-bit accumulators. The first accumulator collects the bit addresses of all set bits. The second collects the complements of those addresses. When a page is written, the two accumulators form the four-byte code that software places in the spare area.

When a page is read back, the four stored code bytes follow the last data word directly. They are folded into the same accumulators, so that at the end the accumulators hold the syndrome. The engine sorts the syndrome into four outcomes: clean, one correctable data-bit error, an error inside the stored code, or a multiple error. For a correctable error it also reports the word and bit position of the faulty bit. A freshly erased page shows up as a multiple error whose locator is all ones, and software can recognise it from that.

Each page starts with a one-cycle start pulse. The start pulse captures the page size, the bus width and the direction. A one-cycle done pulse marks the moment from which the results can be read.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, `done_o`, all three error flags, `par1_o` and `par2_o` are zero.
- R2: At `start_i`, `page_sel_i` selects the data area that the code covers: 0 gives 512 bytes, 1 gives 1024, 2 gives 2048 and 3 gives 4096 (page totals of 528, 1056, 2112 and 4224 bytes with the spare area). One beat carries one byte when `bus16_i`=0 and two bytes when `bus16_i`=1, so a page has bytes/width data beats.
- R3: `done_o` is high for exactly one cycle. It rises in the cycle after the final beat is accepted: the last data beat for a write page (`read_i`=0), or the last code beat for a read page (`read_i`=1). The outputs are valid from that cycle on.
- R4: On a write page, `par1_o` equals the XOR, over every set data bit, of the 16-bit address {word index[11:0], bit index[3:0]}. `par2_o` equals the XOR of the bitwise complements of those addresses.
- R5: On a read page, the code beats follow the last data beat with nothing in between. On an 8-bit bus there are four beats carrying, in `data_i[7:0]`, the low then high byte of the first word, then the low then high byte of the second word. On a 16-bit bus there are two beats: the first word, then the second word. After done, `par1_o`/`par2_o` hold the syndrome, which is the computed code XOR the stored code. A page that matches its code gives zero syndrome and no flag.
- R6: A single flipped data bit sets `rec_err_o` only. `par1_o[3:0]` then gives its bit index, `par1_o[15:4]` gives its word index, and `par2_o` is the complement of `par1_o`.
- R7: On a 16-bit bus, data bits 8 to 15 are covered and located with bit indices 8 to 15. On an 8-bit bus, `data_i[15:8]` has no effect on the code.
- R8: A syndrome with exactly one bit set across both words sets `rec_err_o` and `code_err_o`, and leaves `mul_err_o` low.
- R9: Any other nonzero syndrome in which the two words are not complements sets `rec_err_o` and `mul_err_o`, for example when two data bits are flipped.
- R10: A page whose data and stored code are all ones reports `mul_err_o`=1 with `par1_o`=16'hFFFF and `par2_o`=16'hFFFF.
- R11: `start_i` clears the accumulators and the flags in the following cycle. The flags then keep their values until the next page finishes, and the reported results keep their values until the next `start_i`.
- R12: Beats presented while no page is open are ignored: before the first start, after done, and in the cycle of `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-page pulse; captures configuration |
| page_sel_i | input | 2 | Data area size select (512 << value bytes) |
| bus16_i | input | 1 | 1 selects a 16-bit data bus, 0 an 8-bit bus |
| read_i | input | 1 | 1 for a read page with code beats, 0 for a write page |
| vld_i | input | 1 | A beat is present on `data_i` |
| data_i | input | 16 | Data or code beat |
| done_o | output | 1 | One-cycle pulse when results are ready |
| par1_o | output | 16 | First code word (write) or syndrome/locator (read) |
| par2_o | output | 16 | Complementary code word (write) or syndrome (read) |
| rec_err_o | output | 1 | Nonzero syndrome seen |
| code_err_o | output | 1 | Error lies in the stored code |
| mul_err_o | output | 1 | Uncorrectable multiple error |

## Verification
A wrong beat counter or a wrong size decode moves the done pulse to the wrong cycle, and the reference model checks the done level in every cycle of a page. Such a fault therefore shows up at the first beat where the model and the design disagree. A mistake in a bit lane or an address field in the folding logic changes `par1_o` or `par2_o` at the next done pulse. A mistake in the syndrome classification shows up in the flags in that same cycle. Wrong ordering of the code bytes shows up as false code or multiple errors on pages that match their stored code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CODE = 2'd2
  } ecc_state_e;

  localparam int unsigned BASE_BYTES = 512;

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int unsigned CW  = 13,
  parameter int unsigned WAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     page_sel_i,
  input  logic           bus16_i,
  input  logic           read_i,
  input  logic           vld_i,
  output logic           data_beat_o,
  output logic           code_beat_o,
  output logic [1:0]     code_idx_o,
  output logic           last_beat_o,
  output logic [WAW-1:0] waddr_o,
  output logic           bus16_q_o,
  output logic           rd_q_o,
  output logic           done_o
);

  ecc_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    sel_q, sel_n;
  logic          b16_q, b16_n;
  logic          rd_q, rd_n;
  logic          done_q;
  logic          reg_en;
  logic [CW-1:0] words;
  logic          last_data;
  logic          last_code;

  // number of data beats in the page, from size select and bus width
  assign words     = (CW'(BASE_BYTES) << sel_q) >> b16_q;
  assign last_data = (cnt_q == words - CW'(1));
  assign last_code = (cnt_q[1:0] == (b16_q ? 2'd1 : 2'd3));

  always_comb begin
    st_n        = st_q;
    cnt_n       = cnt_q;
    sel_n       = sel_q;
    b16_n       = b16_q;
    rd_n        = rd_q;
    data_beat_o = vld_i && !start_i && (st_q == ST_DATA);
    code_beat_o = vld_i && !start_i && (st_q == ST_CODE);
    last_beat_o = (data_beat_o && last_data && !rd_q) ||
                  (code_beat_o && last_code);
    if (start_i) begin
      st_n  = ST_DATA;
      cnt_n = '0;
      sel_n = page_sel_i;
      b16_n = bus16_i;
      rd_n  = read_i;
    end else if (data_beat_o) begin
      if (last_data) begin
        cnt_n = '0;
        st_n  = rd_q ? ST_CODE : ST_IDLE;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end else if (code_beat_o) begin
      if (last_code) begin
        cnt_n = '0;
        st_n  = ST_IDLE;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  assign reg_en = start_i || data_beat_o || code_beat_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_q <= '0;
      b16_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (reg_en) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sel_q <= sel_n;
      b16_q <= b16_n;
      rd_q  <= rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_beat_o;
  end

  // on a 16-bit bus the two code words sit at byte slots 0 and 2
  assign code_idx_o = b16_q ? {cnt_q[0], 1'b0} : cnt_q[1:0];
  assign waddr_o    = cnt_q[WAW-1:0];
  assign bus16_q_o  = b16_q;
  assign rd_q_o     = rd_q;
  assign done_o     = done_q;

endmodule

// File: rtl/nand_ecc_fold.sv
module nand_ecc_fold #(
  parameter int unsigned DW  = 16,
  parameter int unsigned WAW = 12,
  parameter int unsigned BAW = 4
) (
  input  logic [WAW-1:0]     waddr_i,
  input  logic [DW-1:0]      data_i,
  input  logic               bus16_i,
  output logic [WAW+BAW-1:0] c1_o,
  output logic [WAW+BAW-1:0] c2_o
);

  localparam int unsigned LW   = WAW + BAW;
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0][LW-1:0] t1;
  logic [DW-1:0][LW-1:0] t2;

  for (genvar g = 0; g < DW; g++) begin : g_lane
    logic lane_on;
    if (g < HALF) begin : g_low
      assign lane_on = data_i[g];
    end else begin : g_high
      assign lane_on = data_i[g] && bus16_i;
    end
    assign t1[g] = lane_on ?  {waddr_i, BAW'(g)} : '0;
    assign t2[g] = lane_on ? ~{waddr_i, BAW'(g)} : '0;
  end

  always_comb begin
    c1_o = '0;
    c2_o = '0;
    for (int i = 0; i < DW; i++) begin
      c1_o = c1_o ^ t1[i];
      c2_o = c2_o ^ t2[i];
    end
  end

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify #(
  parameter int unsigned LW = 16
) (
  input  logic [LW-1:0] s1_i,
  input  logic [LW-1:0] s2_i,
  output logic          rec_o,
  output logic          code_o,
  output logic          mul_o
);

  logic [2*LW-1:0] s_all;
  logic            one_hot;
  logic            cplm;

  assign s_all   = {s2_i, s1_i};
  assign one_hot = (s_all != '0) && ((s_all & (s_all - 1'b1)) == '0);
  assign cplm    = ((s1_i ^ s2_i) == '1);

  always_comb begin
    rec_o  = (s_all != '0);
    code_o = one_hot;
    mul_o  = rec_o && !one_hot && !cplm;
  end

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
  parameter int unsigned LW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          data_beat_i,
  input  logic          code_beat_i,
  input  logic [1:0]    code_idx_i,
  input  logic          bus16_i,
  input  logic [DW-1:0] din_i,
  input  logic [LW-1:0] c1_i,
  input  logic [LW-1:0] c2_i,
  input  logic          flag_ld_i,
  input  logic          rec_i,
  input  logic          code_i,
  input  logic          mul_i,
  output logic [LW-1:0] acc1_o,
  output logic [LW-1:0] acc2_o,
  output logic [LW-1:0] nxt1_o,
  output logic [LW-1:0] nxt2_o,
  output logic          rec_o,
  output logic          code_o,
  output logic          mul_o
);

  localparam int unsigned HB = LW / 2;

  logic [LW-1:0] acc1_q, acc2_q;
  logic          rec_q, code_q, mul_q;
  logic          rec_n, code_n, mul_n;
  logic          acc_en, flag_en;

  always_comb begin
    nxt1_o = acc1_q;
    nxt2_o = acc2_q;
    if (clr_i) begin
      nxt1_o = '0;
      nxt2_o = '0;
    end else if (data_beat_i) begin
      nxt1_o = acc1_q ^ c1_i;
      nxt2_o = acc2_q ^ c2_i;
    end else if (code_beat_i) begin
      if (bus16_i) begin
        if (!code_idx_i[1]) nxt1_o = acc1_q ^ din_i[LW-1:0];
        else                nxt2_o = acc2_q ^ din_i[LW-1:0];
      end else begin
        case (code_idx_i)
          2'd0:    nxt1_o[HB-1:0]  = acc1_q[HB-1:0]  ^ din_i[HB-1:0];
          2'd1:    nxt1_o[LW-1:HB] = acc1_q[LW-1:HB] ^ din_i[HB-1:0];
          2'd2:    nxt2_o[HB-1:0]  = acc2_q[HB-1:0]  ^ din_i[HB-1:0];
          default: nxt2_o[LW-1:HB] = acc2_q[LW-1:HB] ^ din_i[HB-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rec_n  = rec_q;
    code_n = code_q;
    mul_n  = mul_q;
    if (clr_i) begin
      rec_n  = 1'b0;
      code_n = 1'b0;
      mul_n  = 1'b0;
    end else if (flag_ld_i) begin
      rec_n  = rec_i;
      code_n = code_i;
      mul_n  = mul_i;
    end
  end

  assign acc_en  = clr_i || data_beat_i || code_beat_i;
  assign flag_en = clr_i || flag_ld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1_q <= '0;
      acc2_q <= '0;
    end else if (acc_en) begin
      acc1_q <= nxt1_o;
      acc2_q <= nxt2_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= 1'b0;
      code_q <= 1'b0;
      mul_q  <= 1'b0;
    end else if (flag_en) begin
      rec_q  <= rec_n;
      code_q <= code_n;
      mul_q  <= mul_n;
    end
  end

  assign acc1_o = acc1_q;
  assign acc2_o = acc2_q;
  assign rec_o  = rec_q;
  assign code_o = code_q;
  assign mul_o  = mul_q;

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc #(
  parameter int unsigned DW  = 16,
  parameter int unsigned WAW = 12,
  parameter int unsigned BAW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [1:0]           page_sel_i,
  input  logic                 bus16_i,
  input  logic                 read_i,
  input  logic                 vld_i,
  input  logic [DW-1:0]        data_i,
  output logic                 done_o,
  output logic [WAW+BAW-1:0]   par1_o,
  output logic [WAW+BAW-1:0]   par2_o,
  output logic                 rec_err_o,
  output logic                 code_err_o,
  output logic                 mul_err_o
);

  localparam int unsigned LW = WAW + BAW;
  localparam int unsigned CW = WAW + 1;

  logic           rst_m_q, rst_s_q;
  logic           data_beat, code_beat, last_beat;
  logic [1:0]     code_idx;
  logic [WAW-1:0] waddr;
  logic           b16_q, rd_q;
  logic [LW-1:0]  c1, c2, nxt1, nxt2;
  logic           cl_rec, cl_code, cl_mul;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  nand_ecc_ctrl #(.CW(CW), .WAW(WAW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .start_i     (start_i),
    .page_sel_i  (page_sel_i),
    .bus16_i     (bus16_i),
    .read_i      (read_i),
    .vld_i       (vld_i),
    .data_beat_o (data_beat),
    .code_beat_o (code_beat),
    .code_idx_o  (code_idx),
    .last_beat_o (last_beat),
    .waddr_o     (waddr),
    .bus16_q_o   (b16_q),
    .rd_q_o      (rd_q),
    .done_o      (done_o)
  );

  nand_ecc_fold #(.DW(DW), .WAW(WAW), .BAW(BAW)) u_fold (
    .waddr_i (waddr),
    .data_i  (data_i),
    .bus16_i (b16_q),
    .c1_o    (c1),
    .c2_o    (c2)
  );

  nand_ecc_classify #(.LW(LW)) u_cls (
    .s1_i   (nxt1),
    .s2_i   (nxt2),
    .rec_o  (cl_rec),
    .code_o (cl_code),
    .mul_o  (cl_mul)
  );

  nand_ecc_accum #(.LW(LW), .DW(DW)) u_acc (
    .clk         (clk),
    .rst_n       (rst_s_q),
    .clr_i       (start_i),
    .data_beat_i (data_beat),
    .code_beat_i (code_beat),
    .code_idx_i  (code_idx),
    .bus16_i     (b16_q),
    .din_i       (data_i),
    .c1_i        (c1),
    .c2_i        (c2),
    .flag_ld_i   (last_beat && rd_q),
    .rec_i       (cl_rec),
    .code_i      (cl_code),
    .mul_i       (cl_mul),
    .acc1_o      (par1_o),
    .acc2_o      (par2_o),
    .nxt1_o      (nxt1),
    .nxt2_o      (nxt2),
    .rec_o       (rec_err_o),
    .code_o      (code_err_o),
    .mul_o       (mul_err_o)
  );

endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk #(
  parameter int unsigned LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic [LW-1:0] par1_o,
  input logic [LW-1:0] par2_o,
  input logic          rec_err_o,
  input logic          code_err_o,
  input logic          mul_err_o,
  input logic          rd_q
);

  // R3: done never lasts two cycles
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: start clears results and flags
  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !rec_err_o && !code_err_o && !mul_err_o &&
                 par1_o == '0 && par2_o == '0));

  // R11: flags change only together with done or after start
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (done_o || $stable({rec_err_o, code_err_o, mul_err_o})));

  // R5: clean read page leaves zero syndrome
  p_clean_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rd_q && !rec_err_o) |-> (par1_o == '0 && par2_o == '0));

  // R6: correctable data error has complementary syndrome halves
  p_single_cplm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && rec_err_o && !code_err_o && !mul_err_o) |->
      ((par1_o ^ par2_o) == '1));

  // R8: code error means exactly one syndrome bit
  p_code_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && code_err_o) |-> ($countones({par2_o, par1_o}) == 1));

  // R9: multiple error implies recoverable flag and excludes code error
  p_mul_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mul_err_o |-> (rec_err_o && !code_err_o));

endmodule

bind nand_page_ecc nand_page_ecc_chk #(.LW(WAW + BAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .done_o     (done_o),
  .par1_o     (par1_o),
  .par2_o     (par2_o),
  .rec_err_o  (rec_err_o),
  .code_err_o (code_err_o),
  .mul_err_o  (mul_err_o),
  .rd_q       (rd_q)
);

// File: tb/nand_page_ecc_bench.sv
module nand_page_ecc_bench;

  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  page_sel_i = '0;
  logic        bus16_i = 1'b0;
  logic        read_i = 1'b0;
  logic        vld_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        done_o;
  logic [15:0] par1_o, par2_o;
  logic        rec_err_o, code_err_o, mul_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] pg [4096];
  logic [15:0] ep1, ep2;

  always #(CYC/2) clk = ~clk;

  nand_page_ecc u_nand_page_ecc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_sel_i(page_sel_i),
    .bus16_i(bus16_i), .read_i(read_i), .vld_i(vld_i), .data_i(data_i),
    .done_o(done_o), .par1_o(par1_o), .par2_o(par2_o),
    .rec_err_o(rec_err_o), .code_err_o(code_err_o), .mul_err_o(mul_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural code of the page held in pg
  task automatic model(input int sel, input int b16);
    int nw = (512 << sel) >> b16;
    int lanes = b16 ? 16 : 8;
    ep1 = '0;
    ep2 = '0;
    for (int w = 0; w < nw; w++)
      for (int b = 0; b < lanes; b++)
        if (pg[w][b]) begin
          logic [15:0] a = {w[11:0], b[3:0]};
          ep1 ^= a;
          ep2 ^= ~a;
        end
  endtask

  task automatic fill(input int seed, input bit dirty_hi);
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] v = (i * 32'h9E3779B1) ^ (seed * 32'h85EBCA6B);
      v = v ^ (v >> 13);
      pg[i] = dirty_hi ? v[15:0] : {8'h00, v[7:0]};
    end
  endtask

  // runs one page; for read pages, stored is {p2,p1}; results left in outputs
  task automatic run_page(input int sel, input int b16, input bit rd,
                          input logic [31:0] stored, input string req);
    int nw = (512 << sel) >> b16;
    logic [15:0] bq[$];
    logic [15:0] h1, h2;
    for (int i = 0; i < nw; i++) bq.push_back(pg[i]);
    if (rd) begin
      if (b16) begin
        bq.push_back(stored[15:0]);
        bq.push_back(stored[31:16]);
      end else begin
        bq.push_back({8'h00, stored[7:0]});
        bq.push_back({8'h00, stored[15:8]});
        bq.push_back({8'h00, stored[23:16]});
        bq.push_back({8'h00, stored[31:24]});
      end
    end
    start_i = 1'b1; page_sel_i = 2'(sel); bus16_i = b16[0]; read_i = rd;
    vld_i = 1'b1; data_i = 16'hA5A5;  // R12: beat in start cycle ignored
    @(negedge clk);
    start_i = 1'b0;
    chk(par1_o == 0 && par2_o == 0 && !rec_err_o && !code_err_o && !mul_err_o && !done_o,
        "R11 clear", {par1_o, par2_o, 28'd0, rec_err_o, code_err_o, mul_err_o, done_o}, 0);
    for (int k = 0; k < bq.size(); k++) begin
      vld_i = 1'b1;
      data_i = bq[k];
      @(negedge clk);
      chk(done_o == (k == bq.size() - 1), "R3 done timing", 64'(done_o),
          64'(k == bq.size() - 1));
    end
    vld_i = 1'b0;
    data_i = '0;
    h1 = par1_o;
    h2 = par2_o;
    @(negedge clk);
    chk(!done_o && par1_o == h1 && par2_o == h2, "R3 single pulse and hold",
        {done_o, 31'd0, par1_o, par2_o}, {32'd0, h1, h2});
    $display("page %s sel=%0d b16=%0d rd=%0d done", req, sel, b16, rd);
  endtask

  task automatic expect_read(input logic [31:0] stored, input string req);
    logic [15:0] s1 = ep1 ^ stored[15:0];
    logic [15:0] s2 = ep2 ^ stored[31:16];
    bit r = ({s2, s1} != 0);
    bit c = ($countones({s2, s1}) == 1);
    bit m = r && !c && ((s1 ^ s2) != 16'hFFFF);
    chk(par1_o == s1 && par2_o == s2, req, {par1_o, par2_o}, {s1, s2});
    chk(rec_err_o == r && code_err_o == c && mul_err_o == m, req,
        {rec_err_o, code_err_o, mul_err_o}, {r, c, m});
  endtask

  logic [31:0] good;
  logic [15:0] q1, q2;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: beats before any start are ignored
    vld_i = 1'b1; data_i = 16'hFFFF;
    repeat (4) @(negedge clk);
    vld_i = 1'b0;
    chk(!done_o && par1_o == 0 && par2_o == 0 && !rec_err_o && !code_err_o && !mul_err_o,
        "R1 R12 reset state", {par1_o, par2_o}, 0);

    // R4 R2: write page, 528-byte mode, 8-bit bus
    fill(1, 1'b0);
    model(0, 0);
    run_page(0, 0, 1'b0, 32'd0, "write528");
    chk(par1_o == ep1 && par2_o == ep2, "R4 write code", {par1_o, par2_o}, {ep1, ep2});
    good = {ep2, ep1};

    // R12: beats after done are ignored
    q1 = par1_o; q2 = par2_o;
    vld_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      data_i = 16'(i * 16'h1357 + 16'h00FF);
      @(negedge clk);
      chk(!done_o && par1_o == q1 && par2_o == q2, "R12 after done",
          {done_o, 31'd0, par1_o, par2_o}, {32'd0, q1, q2});
    end
    vld_i = 1'b0;

    // R5: clean read
    run_page(0, 0, 1'b1, good, "clean");
    expect_read(good, "R5 clean read");
    chk(par1_o == 0 && !rec_err_o, "R5 zero syndrome", {par1_o, 15'd0, rec_err_o}, 0);

    // R6: single data bit at word 100 bit 5
    pg[100][5] = ~pg[100][5];
    model(0, 0);
    run_page(0, 0, 1'b1, good, "single");
    expect_read(good, "R6 single data error");
    chk(par1_o == 16'h0645 && par2_o == 16'hF9BA && rec_err_o && !code_err_o && !mul_err_o,
        "R6 locator", {par1_o, par2_o}, {16'h0645, 16'hF9BA});

    // R11: flags hold until next start
    repeat (3) @(negedge clk);
    chk(rec_err_o && par1_o == 16'h0645, "R11 flags hold", {par1_o, 15'd0, rec_err_o},
        {16'h0645, 16'd1});
    pg[100][5] = ~pg[100][5];

    // R8: single bit in stored code (byte 1 bit 0 -> syndrome bit 8)
    model(0, 0);
    run_page(0, 0, 1'b1, good ^ 32'h0000_0100, "codeerr");
    expect_read(good ^ 32'h0000_0100, "R8 code error");
    chk(code_err_o && rec_err_o && !mul_err_o && par1_o == 16'h0100, "R8 flags",
        {par1_o, 13'd0, rec_err_o, code_err_o, mul_err_o}, {16'h0100, 16'h0006});

    // R9: two data bits flipped
    pg[7][1] = ~pg[7][1];
    pg[300][6] = ~pg[300][6];
    model(0, 0);
    run_page(0, 0, 1'b1, good, "double");
    expect_read(good, "R9 double error");
    chk(mul_err_o && rec_err_o && !code_err_o, "R9 flags",
        {rec_err_o, code_err_o, mul_err_o}, 3'b101);

    // R7: 8-bit bus ignores upper data byte
    fill(1, 1'b1);
    run_page(0, 0, 1'b0, 32'd0, "dirtyhi");
    chk({par2_o, par1_o} == good, "R7 upper byte ignored", {par2_o, par1_o}, good);

    // R7 R2: 16-bit bus, 1056-byte page, error in bit 13
    fill(2, 1'b1);
    model(1, 1);
    run_page(1, 1, 1'b0, 32'd0, "write1056w");
    chk(par1_o == ep1 && par2_o == ep2, "R2 R4 write 16-bit", {par1_o, par2_o}, {ep1, ep2});
    good = {ep2, ep1};
    pg[300][13] = ~pg[300][13];
    model(1, 1);
    run_page(1, 1, 1'b1, good, "single16");
    expect_read(good, "R7 16-bit locate");
    chk(par1_o == 16'h12CD && rec_err_o && !mul_err_o && !code_err_o, "R7 bit 13 locator",
        {par1_o, 15'd0, rec_err_o}, {16'h12CD, 16'd1});

    // R10: erased page, 16-bit bus
    for (int i = 0; i < 4096; i++) pg[i] = 16'hFFFF;
    model(1, 1);
    run_page(1, 1, 1'b1, 32'hFFFF_FFFF, "erased");
    expect_read(32'hFFFF_FFFF, "R10 erased page");
    chk(mul_err_o && par1_o == 16'hFFFF && par2_o == 16'hFFFF, "R10 all-ones locator",
        {par1_o, par2_o}, {16'hFFFF, 16'hFFFF});

    // R2: 2112-byte page on 16-bit bus and 4224-byte page on 8-bit bus
    fill(3, 1'b1);
    model(2, 1);
    run_page(2, 1, 1'b0, 32'd0, "write2112w");
    chk(par1_o == ep1 && par2_o == ep2, "R2 2112 size", {par1_o, par2_o}, {ep1, ep2});
    model(3, 0);
    run_page(3, 0, 1'b0, 32'd0, "write4224");
    chk(par1_o == ep1 && par2_o == ep2, "R2 4224 size", {par1_o, par2_o}, {ep1, ep2});
    good = {ep2, ep1};
    pg[4095][7] = ~pg[4095][7];
    model(3, 0);
    run_page(3, 0, 1'b1, good, "last4224");
    expect_read(good, "R6 last word locate");
    chk(par1_o == 16'hFFF7, "R6 word 4095 bit 7", {48'd0, par1_o}, {48'd0, 16'hFFF7});

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CYC * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule